// File: doc/BRIEF.md
# Streaming Hash Intake Controller

This block sits between a register bus and a hash compression core that runs either SHA-1 or SHA-256. Software programs a configuration word, writes a start trigger, and then streams message data into a single data port using any mix of 8-bit and 32-bit writes. The block packs those writes into 32-bit beats and hands them to the core over a valid/ready handshake. Up to four beats are buffered, and the bus is stalled once that buffer fills.

A stop trigger closes the message. Any bytes still waiting for a full word go out as a final beat that carries a byte count and a last flag. If no bytes are waiting, an empty terminating beat goes out instead. Padding and the compression rounds belong to the core. When the core reports completion, a sticky done status is set, an interrupt can be raised, and the digest words can be read back by index.

Top module: `hash_stream_front`

## Requirements
- R1: After reset the configuration reads 0, the status reads 0, and irq_o, core_valid_o, bus_wait_o and bus_err_o are all low.
- R2: The configuration register at byte address 0x00 holds three bits: bit 0 enables stream intake, bit 1 enables the interrupt, and bit 2 selects SHA-1 (clear means SHA-256). Reads return these bits with all other bits zero, and core_sha1_o follows bit 2.
- R3: Writing bit 0 of the trigger register (0x04) starts a message and pulses core_start_o for that cycle. Writes to the data port (0x0C) are accepted only while a message is running and the intake bit is set. Otherwise they are ignored and produce no beat.
- R4: 8-bit data writes are packed big-endian: the first byte lands in bits 31:24. Each completed word, and each accepted 32-bit write, produces one beat with core_nbytes_o = 4 and core_last_o = 0.
- R5: A 32-bit data write that arrives while 1 to 3 bytes are pending raises bus_err_o in that cycle and is dropped. The pending bytes are kept.
- R6: Beats are held in a 4-entry FIFO and leave in write order. A data write or stop that meets a full FIFO sees bus_wait_o high and is held until space frees.
- R7: Writing bit 1 of the trigger register while running ends the message with one beat where core_last_o = 1. That beat has core_nbytes_o equal to the pending byte count (0 to 3), with the bytes left-aligned and the remaining bits zero. Intake then stops.
- R8: Writing the stop bit while no message is running produces no beat, no wait and no error.
- R9: core_done_i sets a done status, read as bit 0 at address 0x08. The status stays set until a write of zero to 0x08; a non-zero write leaves it set.
- R10: irq_o equals the done status ANDed with configuration bit 1.
- R11: The digest is captured when core_done_i is high. Word i reads at 0x40 + 4*i and equals core_digest_i[32*i+31:32*i]. In SHA-1 mode, indices 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 8 | Bus byte address |
| bus_word_i | input | 1 | 1 = 32-bit write, 0 = 8-bit write (data in bits 7:0) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| bus_wait_o | output | 1 | Write stalled; hold the write until low |
| bus_err_o | output | 1 | Current data write rejected |
| irq_o | output | 1 | Done interrupt |
| core_start_o | output | 1 | Message start pulse to the core |
| core_sha1_o | output | 1 | Mode to the core, 1 = SHA-1 |
| core_valid_o | output | 1 | Beat valid |
| core_ready_i | input | 1 | Core accepts beat |
| core_data_o | output | 32 | Beat data, big-endian |
| core_nbytes_o | output | 3 | Valid bytes in beat, 0 to 4 |
| core_last_o | output | 1 | Final beat of message |
| core_done_i | input | 1 | Core finished, digest valid |
| core_digest_i | input | 256 | Digest words from the core |

## Verification
Three properties are checked on every cycle. The FIFO never takes a push while full, and a stalled beat keeps its data. Beats are only produced while a message is running, and a rejected word write never produces a beat. The done status never drops without a zero write to the status register. The byte ordering, the content of the final partial beat, the dropping of intake while idle or with intake disabled, the interrupt gating, and the mode-dependent digest limit all depend on concrete values. The bench's directed scenarios show those by comparing the beats and readback against values computed from the requirements.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NB_W = 3;

  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_TRIG  = 8'h04;
  localparam logic [7:0] A_STAT  = 8'h08;
  localparam logic [7:0] A_DATA  = 8'h0C;

  localparam int unsigned CFG_W     = 3;
  localparam int unsigned CFG_LIVE  = 0;
  localparam int unsigned CFG_IRQEN = 1;
  localparam int unsigned CFG_SHA1  = 2;
  localparam int unsigned TRIG_GO   = 0;
  localparam int unsigned TRIG_STOP = 1;

  typedef struct packed {
    logic [DW-1:0]   data;
    logic [NB_W-1:0] nbytes;
    logic            last;
  } beat_t;
endpackage

// File: rtl/hsf_packer.sv
module hsf_packer
  import hsf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          byte_we_i,
  input  logic          word_we_i,
  input  logic          flush_i,
  input  logic [DW-1:0] wdata_i,
  output logic          push_o,
  output beat_t         beat_o,
  output logic          err_o
);
  logic [23:0] acc_q, acc_d;
  logic [1:0]  cnt_q, cnt_d;

  always_comb begin
    push_o = 1'b0;
    beat_o = '0;
    err_o  = 1'b0;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (byte_we_i) begin
      if (cnt_q == 2'd3) begin
        push_o        = 1'b1;
        beat_o.data   = {acc_q, wdata_i[7:0]};
        beat_o.nbytes = 3'd4;
        acc_d         = '0;
        cnt_d         = '0;
      end else begin
        acc_d = {acc_q[15:0], wdata_i[7:0]};
        cnt_d = cnt_q + 2'd1;
      end
    end else if (word_we_i) begin
      if (cnt_q == 2'd0) begin
        push_o        = 1'b1;
        beat_o.data   = wdata_i;
        beat_o.nbytes = 3'd4;
      end else begin
        err_o = 1'b1;
      end
    end else if (flush_i) begin
      push_o        = 1'b1;
      beat_o.last   = 1'b1;
      beat_o.nbytes = {1'b0, cnt_q};
      unique case (cnt_q)
        2'd0: beat_o.data = '0;
        2'd1: beat_o.data = {acc_q[7:0], 24'h0};
        2'd2: beat_o.data = {acc_q[15:0], 16'h0};
        default: beat_o.data = {acc_q, 8'h0};
      endcase
      acc_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  a_r3_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_we_i, word_we_i, flush_i}));
  // R5: a rejected word write keeps the pending byte count
  a_r5_err_keeps_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/hsf_fifo.sv
module hsf_fifo #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rd_q];
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(do_pop);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r6_hold_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !pop_i) |=> (!empty_o && $stable(rdata_o)));
endmodule

// File: rtl/hsf_digest.sv
module hsf_digest #(
  parameter int unsigned NW = 8,
  parameter int unsigned DW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [NW*DW-1:0]   digest_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [IW:0]        limit_i,
  output logic [DW-1:0]      word_o
);
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1;

  logic [DW-1:0] word_q [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        word_q[g] <= '0;
      else if (capture_i) word_q[g] <= digest_i[g*DW +: DW];
    end
  end

  assign word_o = ({1'b0, idx_i} < limit_i && 32'(idx_i) < NW) ? word_q[idx_i] : '0;
endmodule

// File: rtl/hash_stream_front.sv
module hash_stream_front
  import hsf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH   = 4,
  parameter int unsigned DIGEST_WORDS = 8,
  parameter int unsigned SHA1_WORDS   = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_we_i,
  input  logic [7:0]                 bus_addr_i,
  input  logic                       bus_word_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic                       bus_wait_o,
  output logic                       bus_err_o,
  output logic                       irq_o,
  output logic                       core_start_o,
  output logic                       core_sha1_o,
  output logic                       core_valid_o,
  input  logic                       core_ready_i,
  output logic [31:0]                core_data_o,
  output logic [2:0]                 core_nbytes_o,
  output logic                       core_last_o,
  input  logic                       core_done_i,
  input  logic [DIGEST_WORDS*32-1:0] core_digest_i
);
  localparam int unsigned IW = (DIGEST_WORDS > 1) ? $clog2(DIGEST_WORDS) : 1;
  localparam int unsigned BW = $bits(beat_t);

  logic [CFG_W-1:0] cfg_q;
  logic             run_q, done_q;
  logic             wr_cfg, wr_trig, wr_stat, wr_data;
  logic             go, stop_req, intake, data_req, stop_push, fifo_full, fifo_empty;
  logic             byte_we, word_we, flush, pk_push, pk_err;
  beat_t            pk_beat, head;
  logic [BW-1:0]    head_raw;
  logic [31:0]      dig_word;
  logic             dig_sel;
  logic [IW:0]      dig_limit;

  assign wr_cfg  = bus_we_i && bus_addr_i == A_CFG;
  assign wr_trig = bus_we_i && bus_addr_i == A_TRIG;
  assign wr_stat = bus_we_i && bus_addr_i == A_STAT;
  assign wr_data = bus_we_i && bus_addr_i == A_DATA;

  assign stop_req  = wr_trig && bus_wdata_i[TRIG_STOP];
  assign go        = wr_trig && bus_wdata_i[TRIG_GO] && !stop_req;
  assign intake    = run_q && cfg_q[CFG_LIVE];
  assign data_req  = wr_data && intake;
  assign stop_push = stop_req && run_q;

  assign bus_wait_o = (data_req || stop_push) && fifo_full;
  assign byte_we    = data_req && !bus_word_i && !fifo_full;
  assign word_we    = data_req && bus_word_i && !fifo_full;
  assign flush      = stop_push && !fifo_full;

  hsf_packer u_packer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (go),
    .byte_we_i (byte_we),
    .word_we_i (word_we),
    .flush_i   (flush),
    .wdata_i   (bus_wdata_i),
    .push_o    (pk_push),
    .beat_o    (pk_beat),
    .err_o     (pk_err)
  );

  hsf_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (pk_push),
    .wdata_i (pk_beat),
    .pop_i   (core_ready_i),
    .rdata_o (head_raw),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  assign head          = beat_t'(head_raw);
  assign core_valid_o  = !fifo_empty;
  assign core_data_o   = head.data;
  assign core_nbytes_o = head.nbytes;
  assign core_last_o   = head.last;
  assign core_start_o  = go;
  assign core_sha1_o   = cfg_q[CFG_SHA1];
  assign bus_err_o     = pk_err;
  assign irq_o         = done_q && cfg_q[CFG_IRQEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata_i[CFG_W-1:0];
      if (flush)   run_q <= 1'b0;
      else if (go) run_q <= 1'b1;
      if (core_done_i)                       done_q <= 1'b1;
      else if (wr_stat && bus_wdata_i == '0) done_q <= 1'b0;
    end
  end

  assign dig_sel   = bus_addr_i[7:6] == 2'b01 && !bus_addr_i[5] && bus_addr_i[1:0] == 2'b00;
  assign dig_limit = cfg_q[CFG_SHA1] ? (IW+1)'(SHA1_WORDS) : (IW+1)'(DIGEST_WORDS);

  hsf_digest #(.NW(DIGEST_WORDS), .DW(32)) u_digest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (core_done_i),
    .digest_i  (core_digest_i),
    .idx_i     (bus_addr_i[IW+1:2]),
    .limit_i   (dig_limit),
    .word_o    (dig_word)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CFG)       bus_rdata_o = 32'(cfg_q);
    else if (bus_addr_i == A_STAT) bus_rdata_o = 32'(done_q);
    else if (dig_sel)              bus_rdata_o = dig_word;
  end

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(wr_stat && bus_wdata_i == '0)) |=> done_q);
  a_r8_push_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_push |-> run_q);
  a_r5_err_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !pk_push);
  a_r7_stop_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !run_q);
endmodule

// File: tb/hash_stream_front_bench.sv
module hash_stream_front_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic         word = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         wait_o, err_o, irq, start, sha1, valid, last;
  logic         ready = 1'b1;
  logic [31:0]  cdata;
  logic [2:0]   nbytes;
  logic         done = 1'b0;
  logic [255:0] digest = '0;

  int checks = 0, errors = 0, nb = 0, starts = 0;
  logic [31:0] bd [64];
  logic [2:0]  bn [64];
  logic        bl [64];

  always #4 clk = ~clk;

  hash_stream_front u_hash_stream_front (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_wait_o(wait_o), .bus_err_o(err_o), .irq_o(irq),
    .core_start_o(start), .core_sha1_o(sha1), .core_valid_o(valid),
    .core_ready_i(ready), .core_data_o(cdata), .core_nbytes_o(nbytes),
    .core_last_o(last), .core_done_i(done), .core_digest_i(digest)
  );

  always @(posedge clk) begin
    if (valid && ready && nb < 64) begin
      bd[nb] = cdata; bn[nb] = nbytes; bl[nb] = last; nb++;
    end
    if (start) starts++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic w, input logic [31:0] d,
                    output logic e, output int waits);
    @(negedge clk);
    we = 1'b1; addr = a; word = w; wdata = d; waits = 0;
    #1;
    while (wait_o) begin waits++; @(negedge clk); #1; end
    e = err_o;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic chk_beat(string req, int i, logic [31:0] d, logic [2:0] n, logic l);
    chk({req, " data"}, bd[i], d);
    chk({req, " nbytes"}, 32'(bn[i]), 32'(n));
    chk({req, " last"}, 32'(bl[i]), 32'(l));
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 cfg", v, 0);
    rd(8'h08, v); chk("R1 stat", v, 0);
    chk("R1 irq/valid/wait/err", {28'b0, irq, valid, wait_o, err_o}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v; logic e; int w;
    bw(8'h00, 1'b1, 32'h7, e, w); rd(8'h00, v);
    chk("R2 cfg 7", v, 7); chk("R2 sha1 out", 32'(sha1), 1);
    bw(8'h00, 1'b1, 32'hFFFF_FFF8, e, w); rd(8'h00, v);
    chk("R2 upper bits dropped", v, 0); chk("R2 sha256 out", 32'(sha1), 0);
  endtask

  task automatic t_bytes();
    logic e; int w, b0, s0;
    bw(8'h00, 1'b1, 32'h1, e, w);
    s0 = starts;
    bw(8'h04, 1'b1, 32'h1, e, w);
    chk("R3 start pulse", 32'(starts - s0), 1);
    b0 = nb;
    bw(8'h0C, 1'b0, 32'hAA, e, w); bw(8'h0C, 1'b0, 32'hBB, e, w);
    bw(8'h0C, 1'b0, 32'hCC, e, w); bw(8'h0C, 1'b0, 32'hDD, e, w);
    bw(8'h0C, 1'b1, 32'h0102_0304, e, w);
    bw(8'h0C, 1'b0, 32'h11, e, w); bw(8'h0C, 1'b0, 32'h22, e, w);
    bw(8'h04, 1'b1, 32'h2, e, w);
    settle();
    chk("R4 beat count", 32'(nb - b0), 3);
    chk_beat("R4 bytes big-endian", b0, 32'hAABB_CCDD, 3'd4, 1'b0);
    chk_beat("R4 word", b0 + 1, 32'h0102_0304, 3'd4, 1'b0);
    chk_beat("R7 partial 2", b0 + 2, 32'h1122_0000, 3'd2, 1'b1);
  endtask

  task automatic t_err();
    logic e; int w, b0;
    bw(8'h04, 1'b1, 32'h1, e, w);
    b0 = nb;
    bw(8'h0C, 1'b0, 32'h5A, e, w); chk("R5 byte no err", 32'(e), 0);
    bw(8'h0C, 1'b1, 32'h1234_5678, e, w); chk("R5 err raised", 32'(e), 1);
    settle(); chk("R5 dropped", 32'(nb - b0), 0);
    bw(8'h0C, 1'b0, 32'h6B, e, w); bw(8'h0C, 1'b0, 32'h7C, e, w);
    bw(8'h0C, 1'b0, 32'h8D, e, w);
    bw(8'h04, 1'b1, 32'h2, e, w);
    settle();
    chk("R5 beats", 32'(nb - b0), 2);
    chk_beat("R5 pending kept", b0, 32'h5A6B_7C8D, 3'd4, 1'b0);
    chk_beat("R7 empty terminator", b0 + 1, 32'h0, 3'd0, 1'b1);
  endtask

  task automatic t_idle();
    logic e; int w, b0;
    b0 = nb;
    bw(8'h04, 1'b1, 32'h2, e, w);
    chk("R8 no wait", 32'(w), 0); chk("R8 no err", 32'(e), 0);
    bw(8'h0C, 1'b1, 32'hDEAD_BEEF, e, w);
    settle(); chk("R3 idle data ignored", 32'(nb - b0), 0);
    bw(8'h00, 1'b1, 32'h0, e, w);
    bw(8'h04, 1'b1, 32'h1, e, w);
    bw(8'h0C, 1'b1, 32'hCAFE_F00D, e, w);
    settle(); chk("R3 intake off ignored", 32'(nb - b0), 0);
    bw(8'h04, 1'b1, 32'h2, e, w);
    settle();
    chk("R7 terminator only", 32'(nb - b0), 1);
    chk_beat("R7 empty last", b0, 32'h0, 3'd0, 1'b1);
  endtask

  task automatic t_backpressure();
    logic e; int w, b0, w5;
    bw(8'h00, 1'b1, 32'h1, e, w);
    bw(8'h04, 1'b1, 32'h1, e, w);
    @(negedge clk); ready = 1'b0;
    b0 = nb;
    for (int i = 0; i < 4; i++) begin
      bw(8'h0C, 1'b1, 32'hF000_0000 + i, e, w);
      chk("R6 no wait below full", 32'(w), 0);
    end
    fork
      bw(8'h0C, 1'b1, 32'hF000_0004, e, w5);
      begin repeat (3) @(negedge clk); ready = 1'b1; end
    join
    chk("R6 wait seen", 32'(w5 > 0), 1);
    bw(8'h04, 1'b1, 32'h2, e, w);
    settle();
    chk("R6 beat count", 32'(nb - b0), 6);
    for (int i = 0; i < 5; i++) chk("R6 order", bd[b0 + i], 32'hF000_0000 + i);
  endtask

  task automatic t_done();
    logic [31:0] v; logic e; int w;
    bw(8'h00, 1'b1, 32'h3, e, w);
    for (int i = 0; i < 8; i++) digest[32*i +: 32] = 32'h0101_0101 * (i + 1);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0; digest = '0;
    rd(8'h08, v); chk("R9 done set", v, 1); chk("R10 irq on", 32'(irq), 1);
    repeat (5) @(negedge clk);
    rd(8'h08, v); chk("R9 done sticky", v, 1);
    bw(8'h08, 1'b1, 32'h2, e, w);
    rd(8'h08, v); chk("R9 nonzero write keeps", v, 1);
    bw(8'h00, 1'b1, 32'h1, e, w);
    chk("R10 irq gated", 32'(irq), 0);
    for (int i = 0; i < 8; i++) begin
      rd(8'h40 + 8'(4 * i), v); chk("R11 sha256 word", v, 32'h0101_0101 * (i + 1));
    end
    bw(8'h00, 1'b1, 32'h7, e, w);
    chk("R10 irq again", 32'(irq), 1);
    for (int i = 0; i < 8; i++) begin
      rd(8'h40 + 8'(4 * i), v);
      chk("R11 sha1 word", v, (i < 5) ? 32'h0101_0101 * (i + 1) : 32'h0);
    end
    bw(8'h08, 1'b1, 32'h0, e, w);
    rd(8'h08, v); chk("R9 cleared", v, 0); chk("R10 irq off", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_bytes();
    t_err();
    t_idle();
    t_backpressure();
    t_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule